// File: doc/BRIEF.md
# Keyed Configuration Port Unit

This block is the configuration front end that a host reaches over a byte-wide I/O bus. Two adjacent I/O addresses form an index/data pair. The index port takes a register number, and the data port then reads or writes the selected register. After reset the port is locked. It opens only when a fixed four-byte key arrives on the index port. A write of a dedicated value to a dedicated register locks it again.

Inside, the register space has a global part and a per-device part. The global part holds a read-only chip identity, a read-only revision and a logical device selector. The per-device part holds an activate bit and a 16-bit I/O base address. It is replicated once for each logical device, and the device selector chooses which copy registers 0x30 and above reach. The devices themselves and any bus bridging sit outside the block.

Top module: `keyed_cfg_port`

## Requirements
- R1: After reset the port is locked, the logical device selector is 0x00, every device is inactive with base 0x0000, and `ioRdValid` is low.
- R2: The port unlocks after the bytes 0x87, 0x01, 0x55, 0x55 are written in that order to the index port (address 0x002E). While unlocked, an index-port write loads the register number, and an index-port read returns it.
- R3: During key matching, a byte that does not match the expected key byte restarts matching. A 0x87 byte always counts as the first key byte, so 0x87 0x87 0x01 0x55 0x55 unlocks.
- R4: While locked, reads of either port return 0xFF. Data-port writes are ignored, and index-port writes do not load the register number.
- R5: Register 0x20 returns the chip identity high byte and 0x21 the low byte. Register 0x22 returns the revision in bits 3:0, with bits 7:4 zero. Writes to these three registers have no effect.
- R6: Register 0x07 is the 8-bit logical device selector, readable and writable through the data port (address 0x002F).
- R7: Each logical device below NUM_DEV has its own activate register 0x30 and base registers 0x60 (high byte) and 0x61 (low byte). Register 0x30 keeps only bit 0 and reads 0 in bits 7:1. When the selector is NUM_DEV or above, these registers read 0x00 and writes to them are ignored.
- R8: Writing 0x02 to register 0x02 locks the port. Any other value written there has no effect, and register contents survive a lock/unlock cycle.
- R9: A read strobe at either port address gives `ioRdValid` high for exactly the next cycle, with the byte in `ioRdData`. Strobes at other addresses produce no read and alter no state. Unimplemented registers read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ioAddr | input | 16 | I/O address of the current access |
| ioWrStb | input | 1 | Write strobe, one cycle per byte |
| ioRdStb | input | 1 | Read strobe, one cycle per byte |
| ioWrData | input | 8 | Write byte |
| ioRdData | output | 8 | Read byte, valid with ioRdValid |
| ioRdValid | output | 1 | Read return valid, one cycle after the strobe |

## Verification
The assertions assume that each bus access is a single-cycle strobe with a stable address and data, and that a read and a write never share a cycle. The bench drives every access as a one-cycle pulse, launched on the falling edge and released on the next falling edge, and never overlaps a read with a write. The properties on locking and unlocking also assume that only the index and data ports change the lock state. The stimulus includes writes to foreign addresses so that this assumption is exercised rather than simply taken for granted.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;
  localparam logic [7:0] REG_EXIT    = 8'h02;
  localparam logic [7:0] EXIT_VALUE  = 8'h02;
  localparam logic [7:0] REG_LDN     = 8'h07;
  localparam logic [7:0] REG_ID_HI   = 8'h20;
  localparam logic [7:0] REG_ID_LO   = 8'h21;
  localparam logic [7:0] REG_REV     = 8'h22;
  localparam logic [7:0] REG_ACT     = 8'h30;
  localparam logic [7:0] REG_BASE_HI = 8'h60;
  localparam logic [7:0] REG_BASE_LO = 8'h61;
  localparam logic [7:0] FLOAT_BYTE  = 8'hFF;

  typedef struct packed {
    logic       wrLdn;
    logic       wrAct;
    logic       wrBaseHi;
    logic       wrBaseLo;
    logic       rdCfg;
    logic       rdIdx;
    logic       rdFloat;
    logic [7:0] wrByte;
    logic [7:0] index;
  } ctrl_strobe_t;
endpackage

// File: rtl/cfgport_ctrl.sv
module cfgport_ctrl
  import cfgport_pkg::*;
#(
  parameter logic [15:0] INDEX_ADDR = 16'h002E,
  parameter logic [15:0] DATA_ADDR  = 16'h002F,
  parameter logic [31:0] UNLOCK_KEY = 32'h8701_5555
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [15:0]  ioAddr,
  input  logic         ioWrStb,
  input  logic         ioRdStb,
  input  logic [7:0]   ioWrData,
  output ctrl_strobe_t strobes,
  output logic         unlocked
);
  localparam int KEY_LEN = 4;
  localparam int POS_W = $clog2(KEY_LEN);
  localparam logic [7:0] FIRST_BYTE = UNLOCK_KEY[8*KEY_LEN-1 -: 8];

  logic [POS_W-1:0] keyPos;
  logic [7:0]       indexQ;
  logic [7:0]       expByte;
  logic             hitIdx, hitDat, dataWr;

  assign hitIdx = (ioAddr == INDEX_ADDR);
  assign hitDat = (ioAddr == DATA_ADDR);
  assign dataWr = ioWrStb && hitDat && unlocked;

  always_comb expByte = UNLOCK_KEY[8*(KEY_LEN-1-int'(keyPos)) +: 8];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      unlocked <= 1'b0;
      keyPos   <= '0;
      indexQ   <= 8'h00;
    end else if (ioWrStb && hitIdx) begin
      if (unlocked) begin
        indexQ <= ioWrData;
      end else if (ioWrData == expByte) begin
        if (int'(keyPos) == KEY_LEN-1) begin
          unlocked <= 1'b1;
          keyPos   <= '0;
        end else begin
          keyPos <= keyPos + 1'b1;
        end
      end else if (ioWrData == FIRST_BYTE) begin
        keyPos <= POS_W'(1);
      end else begin
        keyPos <= '0;
      end
    end else if (dataWr && indexQ == REG_EXIT && ioWrData == EXIT_VALUE) begin
      unlocked <= 1'b0;
    end
  end

  always_comb begin
    strobes          = '0;
    strobes.wrByte   = ioWrData;
    strobes.index    = indexQ;
    strobes.wrLdn    = dataWr && (indexQ == REG_LDN);
    strobes.wrAct    = dataWr && (indexQ == REG_ACT);
    strobes.wrBaseHi = dataWr && (indexQ == REG_BASE_HI);
    strobes.wrBaseLo = dataWr && (indexQ == REG_BASE_LO);
    strobes.rdCfg    = ioRdStb && hitDat && unlocked;
    strobes.rdIdx    = ioRdStb && hitIdx && unlocked;
    strobes.rdFloat  = ioRdStb && (hitDat || hitIdx) && !unlocked;
  end
endmodule

// File: rtl/cfgport_regs.sv
module cfgport_regs
  import cfgport_pkg::*;
#(
  parameter int          NUM_DEV  = 16,
  parameter logic [15:0] CHIP_ID  = 16'h8712,
  parameter logic [3:0]  CHIP_REV = 4'h8
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrl_strobe_t strobes,
  output logic [7:0]   ioRdData,
  output logic         ioRdValid,
  output logic [7:0]   ldn
);
  localparam int SEL_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;

  logic [SEL_W-1:0]      devSel;
  logic                  ldnInRange;
  logic [NUM_DEV-1:0]    actVec;
  logic [NUM_DEV*16-1:0] baseVec;
  logic [7:0]            muxByte;
  logic [15:0]           selBase;

  assign ldnInRange = (int'(ldn) < NUM_DEV);
  assign devSel     = ldn[SEL_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN)              ldn <= 8'h00;
    else if (strobes.wrLdn) ldn <= strobes.wrByte;
  end

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
    logic        actQ;
    logic [15:0] baseQ;
    logic        mine;
    assign mine = ldnInRange && (int'(devSel) == d);
    always_ff @(posedge clk) begin
      if (!rstN) begin
        actQ  <= 1'b0;
        baseQ <= 16'h0000;
      end else if (mine) begin
        if (strobes.wrAct)    actQ        <= strobes.wrByte[0];
        if (strobes.wrBaseHi) baseQ[15:8] <= strobes.wrByte;
        if (strobes.wrBaseLo) baseQ[7:0]  <= strobes.wrByte;
      end
    end
    assign actVec[d]           = actQ;
    assign baseVec[d*16 +: 16] = baseQ;
  end

  assign selBase = ldnInRange ? baseVec[int'(devSel)*16 +: 16] : 16'h0000;

  always_comb begin
    case (strobes.index)
      REG_LDN:     muxByte = ldn;
      REG_ID_HI:   muxByte = CHIP_ID[15:8];
      REG_ID_LO:   muxByte = CHIP_ID[7:0];
      REG_REV:     muxByte = {4'h0, CHIP_REV};
      REG_ACT:     muxByte = {7'h00, ldnInRange && actVec[devSel]};
      REG_BASE_HI: muxByte = selBase[15:8];
      REG_BASE_LO: muxByte = selBase[7:0];
      default:     muxByte = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ioRdData  <= 8'h00;
      ioRdValid <= 1'b0;
    end else begin
      ioRdValid <= strobes.rdCfg || strobes.rdIdx || strobes.rdFloat;
      if (strobes.rdCfg)        ioRdData <= muxByte;
      else if (strobes.rdIdx)   ioRdData <= strobes.index;
      else if (strobes.rdFloat) ioRdData <= FLOAT_BYTE;
    end
  end
endmodule

// File: rtl/keyed_cfg_port.sv
module keyed_cfg_port
  import cfgport_pkg::*;
#(
  parameter logic [15:0] INDEX_ADDR = 16'h002E,
  parameter logic [15:0] DATA_ADDR  = 16'h002F,
  parameter logic [31:0] UNLOCK_KEY = 32'h8701_5555,
  parameter int          NUM_DEV    = 16,
  parameter logic [15:0] CHIP_ID    = 16'h8712,
  parameter logic [3:0]  CHIP_REV   = 4'h8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [15:0] ioAddr,
  input  logic        ioWrStb,
  input  logic        ioRdStb,
  input  logic [7:0]  ioWrData,
  output logic [7:0]  ioRdData,
  output logic        ioRdValid
);
  ctrl_strobe_t strobeBus;
  logic         unlockedW;
  logic [7:0]   ldnW;

  cfgport_ctrl #(
    .INDEX_ADDR(INDEX_ADDR), .DATA_ADDR(DATA_ADDR), .UNLOCK_KEY(UNLOCK_KEY)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWrStb(ioWrStb),
    .ioRdStb(ioRdStb), .ioWrData(ioWrData), .strobes(strobeBus),
    .unlocked(unlockedW)
  );

  cfgport_regs #(
    .NUM_DEV(NUM_DEV), .CHIP_ID(CHIP_ID), .CHIP_REV(CHIP_REV)
  ) regs_i (
    .clk(clk), .rstN(rstN), .strobes(strobeBus), .ioRdData(ioRdData),
    .ioRdValid(ioRdValid), .ldn(ldnW)
  );
endmodule

// File: rtl/cfgport_checker.sv
module cfgport_checker #(
  parameter logic [15:0] INDEX_ADDR = 16'h002E,
  parameter logic [15:0] DATA_ADDR  = 16'h002F
) (
  input logic        clk,
  input logic        rstN,
  input logic [15:0] ioAddr,
  input logic        ioWrStb,
  input logic        ioRdStb,
  input logic [7:0]  ioWrData,
  input logic [7:0]  ioRdData,
  input logic        ioRdValid,
  input logic        unlocked,
  input logic [7:0]  ldn
);
  logic portRd;
  assign portRd = ioRdStb && (ioAddr == INDEX_ADDR || ioAddr == DATA_ADDR);

  AST_READ_RETURNS: assert property (@(posedge clk) disable iff (!rstN)
    portRd |=> ioRdValid);  // R9
  AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !portRd |=> !ioRdValid);  // R9
  AST_LOCKED_READ_FLOAT: assert property (@(posedge clk) disable iff (!rstN)
    (portRd && !unlocked) |=> (ioRdData == 8'hFF));  // R4
  AST_LOCKED_LDN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !unlocked |=> $stable(ldn));  // R4
  AST_UNLOCK_ON_KEY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(unlocked) |-> $past(ioWrStb && ioAddr == INDEX_ADDR && ioWrData == 8'h55));  // R2
  AST_LOCK_ON_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    $fell(unlocked) |-> $past(ioWrStb && ioAddr == DATA_ADDR && ioWrData == 8'h02));  // R8
endmodule

bind keyed_cfg_port cfgport_checker #(
  .INDEX_ADDR(INDEX_ADDR), .DATA_ADDR(DATA_ADDR)
) chk_i (
  .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWrStb(ioWrStb),
  .ioRdStb(ioRdStb), .ioWrData(ioWrData), .ioRdData(ioRdData),
  .ioRdValid(ioRdValid), .unlocked(unlockedW), .ldn(ldnW)
);

// File: tb/keyed_cfg_port_tb_top.sv
module keyed_cfg_port_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] IDX = 16'h002E;
  localparam logic [15:0] DAT = 16'h002F;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] ioAddr = 16'h0000;
  logic        ioWrStb = 1'b0;
  logic        ioRdStb = 1'b0;
  logic [7:0]  ioWrData = 8'h00;
  logic [7:0]  ioRdData;
  logic        ioRdValid;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  logic [7:0] expQ[$];
  string      tagQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  keyed_cfg_port dut_i (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWrStb(ioWrStb),
    .ioRdStb(ioRdStb), .ioWrData(ioWrData), .ioRdData(ioRdData),
    .ioRdValid(ioRdValid)
  );

  // monitor: pops one expected byte per returned read
  always @(negedge clk) begin
    if (rstN && ioRdValid) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL R9 unexpected read return: actual %02h expected none", ioRdData);
      end else begin
        logic [7:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        if (ioRdData !== e) begin
          errors++;
          $display("FAIL %s: actual %02h expected %02h", t, ioRdData, e);
        end
      end
    end
  end

  task automatic busWr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    ioAddr = a; ioWrData = d; ioWrStb = 1'b1;
    @(negedge clk);
    ioWrStb = 1'b0;
  endtask

  task automatic busRd(input logic [15:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    expQ.push_back(e); tagQ.push_back(t);
    ioAddr = a; ioRdStb = 1'b1;
    @(negedge clk);
    ioRdStb = 1'b0;
  endtask

  task automatic setReg(input logic [7:0] r, input logic [7:0] v);
    busWr(IDX, r); busWr(DAT, v);
  endtask

  task automatic expectReg(input logic [7:0] r, input logic [7:0] v, input string t);
    busWr(IDX, r); busRd(DAT, v, t);
  endtask

  task automatic sendKey();
    busWr(IDX, 8'h87); busWr(IDX, 8'h01); busWr(IDX, 8'h55); busWr(IDX, 8'h55);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checks++;
    if (ioRdValid !== 1'b0 || ioRdData !== 8'h00) begin
      errors++;
      $display("FAIL R1 reset outputs: actual valid=%0b data=%02h expected valid=0 data=00",
               ioRdValid, ioRdData);
    end

    // locked reads float
    busRd(DAT, 8'hFF, "R4 locked data read");
    busRd(IDX, 8'hFF, "R4 locked index read");

    // key bytes at a foreign address do not count; read there is silent
    busWr(16'h0080, 8'h87); busWr(16'h0080, 8'h01);
    busWr(16'h0080, 8'h55); busWr(16'h0080, 8'h55);
    busRd(DAT, 8'hFF, "R9 foreign-address key ignored");
    @(negedge clk);
    ioAddr = 16'h0030; ioRdStb = 1'b1;
    @(negedge clk);
    ioRdStb = 1'b0;
    checks++;
    if (ioRdValid !== 1'b0) begin
      errors++;
      $display("FAIL R9 foreign read: actual valid=%0b expected 0", ioRdValid);
    end

    // wrong final byte keeps the port locked
    busWr(IDX, 8'h87); busWr(IDX, 8'h01); busWr(IDX, 8'h55); busWr(IDX, 8'h54);
    busRd(DAT, 8'hFF, "R3 wrong key byte stays locked");

    // mismatch restarts, then full key unlocks
    busWr(IDX, 8'h87); busWr(IDX, 8'h01);
    sendKey();
    busWr(IDX, 8'h07);
    busRd(IDX, 8'h07, "R2 index readback after unlock");
    busRd(DAT, 8'h00, "R1 selector reset value");

    // identity
    expectReg(8'h20, 8'h87, "R5 id high");
    expectReg(8'h21, 8'h12, "R5 id low");
    expectReg(8'h22, 8'h08, "R5 revision");
    setReg(8'h20, 8'h00);
    expectReg(8'h20, 8'h87, "R5 id write ignored");
    expectReg(8'h45, 8'h00, "R9 unimplemented register");

    // reset values of a device
    setReg(8'h07, 8'h0A);
    expectReg(8'h30, 8'h00, "R1 device inactive");
    expectReg(8'h60, 8'h00, "R1 base high reset");
    expectReg(8'h61, 8'h00, "R1 base low reset");

    // per-device copies
    setReg(8'h07, 8'h07);
    setReg(8'h30, 8'hFF); setReg(8'h60, 8'h0A); setReg(8'h61, 8'h00);
    setReg(8'h07, 8'h09);
    setReg(8'h60, 8'h02); setReg(8'h61, 8'h01);
    expectReg(8'h30, 8'h00, "R7 device 9 inactive");
    expectReg(8'h60, 8'h02, "R7 device 9 base high");
    expectReg(8'h61, 8'h01, "R7 device 9 base low");
    setReg(8'h07, 8'h07);
    expectReg(8'h30, 8'h01, "R7 activate keeps bit 0 only");
    expectReg(8'h60, 8'h0A, "R7 device 7 base high");
    expectReg(8'h61, 8'h00, "R7 device 7 base low");
    expectReg(8'h07, 8'h07, "R6 selector readback");

    // selector beyond device count
    setReg(8'h07, 8'h20);
    setReg(8'h30, 8'h01); setReg(8'h60, 8'h55);
    expectReg(8'h30, 8'h00, "R7 out-of-range activate");
    expectReg(8'h60, 8'h00, "R7 out-of-range base");
    expectReg(8'h07, 8'h20, "R6 selector holds 0x20");
    setReg(8'h07, 8'h07);

    // exit register
    busWr(IDX, 8'h02); busWr(DAT, 8'h03);
    busRd(IDX, 8'h02, "R8 other exit value ignored");
    busWr(DAT, 8'h02);
    busRd(DAT, 8'hFF, "R8 locked after exit write");
    busWr(DAT, 8'h09);

    // 0x87 restarts key matching mid-sequence
    busWr(IDX, 8'h87);
    sendKey();
    busRd(IDX, 8'h02, "R4 index not loaded while locked");
    expectReg(8'h07, 8'h07, "R8 selector retained");
    expectReg(8'h30, 8'h01, "R8 activate retained");

    repeat (4) @(negedge clk);
    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL R9 missing read returns: actual %0d pending expected 0", expQ.size());
    end
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule